// File: doc/BRIEF.md
# Privilege-Gated Performance Monitor Register Access

This block keeps the control registers and event counters of a performance monitor and decides, request by request, whether an unprivileged program may read or write them. A two-bit access-control field inside the main control register picks the policy. A user access that the policy refuses raises an exception request with a cause code and changes nothing. An access that the policy permits sees only the bits exposed to user software in the two masked control registers. Counters and the auxiliary control register move whole words.

Privileged requests ignore the policy and the masks. Every request completes in one clock, and the results show on the registered outputs after the edge that sampled the request. Counting events and delivering the exception lie outside this block. A privileged write to the main control register is the only way to change the policy, and the new policy applies from the next request onward.

Top module: `pmu_guard`

## Requirements
- R1: A synchronous reset clears every register to zero and drives rdata, done, exc_valid and exc_cause to zero.
- R2: Every request sampled at a clock edge makes done high for exactly the following cycle. done stays low when no request was sampled.
- R3: A privileged request (priv=1) never raises an exception, and it reads or writes all 64 bits of the selected register. The register selects are: 0 for the main control register, 1 for the second control register, 2 for the auxiliary control register, and 3 to 8 for counters 1 to 6.
- R4: The access-control field sits at bits 19:18 of the main control register, with bit 19 as the upper bit. A user read is refused with cause 1 only when this field is 01. With the field at 00, 10 or 11, a user read succeeds.
- R5: A user write succeeds only when bit 19 is 1 (field 10 or 11). With the field at 00, a user write is refused with cause 2. With the field at 01, a user write is refused with cause 1.
- R6: With the field at 11, any user read or write of counter 5 or counter 6 (selects 7 and 8) is refused with cause 1. This test comes before the read and write rules. Counters 1 to 4 are not affected by it.
- R7: A user read of the main control register returns only bits 31 (freeze), 26 (alert enable) and 7 (alert occurred). All other bits read as zero.
- R8: A user write of the main control register changes only bits 31, 26 and 7. All other bits keep their old value, including the access-control field.
- R9: In the second control register, user access covers only the per-counter user-freeze bits 61, 52, 43, 34, 25 and 16. A read returns zero elsewhere, and a write leaves the other bits unchanged.
- R10: A permitted user access to the auxiliary control register or to a counter moves the full 64-bit value.
- R11: A refused access changes no register and leaves rdata unchanged. exc_valid is high for one cycle, with exc_cause set to 1 (facility unavailable) or 2 (emulation assistance). exc_cause is 0 whenever exc_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 4 | Register select |
| priv | input | 1 | 1 = privileged requester, 0 = user |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data of the last successful read |
| done | output | 1 | One-cycle completion strobe |
| exc_valid | output | 1 | One-cycle exception request |
| exc_cause | output | 2 | 0 none, 1 facility unavailable, 2 emulation assistance |

## Verification
Each result is due one cycle after the request: done, exc_valid, exc_cause and rdata are registered at the edge that samples the request, and a write lands in the register at that same edge. The bench drives every request on a falling edge and reads the outputs on the next falling edge, which lies half a period after the result edge. The bench confirms a refused write and a masked write with a later privileged read, so each of these checks spans two request cycles. The done check also looks one cycle further, where the strobe must have fallen again.

// File: rtl/pmu_acc_pkg.sv
package pmu_acc_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE = 2'd0,
      CAUSE_FAC  = 2'd1,
      CAUSE_EMU  = 2'd2
   } exc_cause_e;

   localparam int CTRL_REGS = 3;  // main, second, auxiliary control

endpackage

// File: rtl/pmu_access_gate.sv
module pmu_access_gate
   import pmu_acc_pkg::*;
#(
   parameter int SEL_W = 4
) (
   input  logic             priv,
   input  logic             is_write,
   input  logic [SEL_W-1:0] sel,
   input  logic [SEL_W-1:0] sel_c5,
   input  logic [SEL_W-1:0] sel_c6,
   input  logic [1:0]       acc,
   output logic             allow,
   output exc_cause_e       cause
);

   logic excluded;
   assign excluded = (acc == 2'b11) && ((sel == sel_c5) || (sel == sel_c6));

   always_comb begin
      allow = 1'b0;
      cause = CAUSE_NONE;
      if (priv) begin
         allow = 1'b1;
      end else if (excluded) begin
         cause = CAUSE_FAC;
      end else if (!is_write) begin
         if (acc == 2'b01) cause = CAUSE_FAC;
         else              allow = 1'b1;
      end else begin
         if (acc[1])             allow = 1'b1;
         else if (acc == 2'b01)  cause = CAUSE_FAC;
         else                    cause = CAUSE_EMU;
      end
   end

endmodule

// File: rtl/pmu_user_mask.sv
module pmu_user_mask #(
   parameter int                DATA_W     = 64,
   parameter int                SEL_W      = 4,
   parameter int                NUM_CNT    = 6,
   parameter logic [DATA_W-1:0] CTL0_UMASK = '1,
   parameter int                FCP_FIRST  = 61,
   parameter int                FCP_STRIDE = 9
) (
   input  logic              priv,
   input  logic [SEL_W-1:0]  sel,
   output logic [DATA_W-1:0] mask
);

   localparam logic [SEL_W-1:0] SEL_CTL0 = SEL_W'(0);
   localparam logic [SEL_W-1:0] SEL_CTL2 = SEL_W'(1);

   logic [DATA_W-1:0] fcp_mask;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam int  DIST = FCP_FIRST - b;
      localparam bit  HIT  = (DIST >= 0) && ((DIST % FCP_STRIDE) == 0) &&
                             ((DIST / FCP_STRIDE) < NUM_CNT);
      assign fcp_mask[b] = HIT;
   end

   always_comb begin
      mask = '1;
      if (!priv) begin
         if (sel == SEL_CTL0)      mask = CTL0_UMASK;
         else if (sel == SEL_CTL2) mask = fcp_mask;
      end
   end

endmodule

// File: rtl/pmu_reg_bank.sv
module pmu_reg_bank #(
   parameter int DATA_W = 64,
   parameter int NREG   = 9,
   parameter int SEL_W  = 4
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        we,
   input  logic [SEL_W-1:0]            sel,
   input  logic [DATA_W-1:0]           wdata,
   input  logic [DATA_W-1:0]           mask,
   output logic [NREG-1:0][DATA_W-1:0] bank
);

   logic [NREG-1:0][DATA_W-1:0] q;

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (we) begin
         for (int i = 0; i < NREG; i++) begin
            if (sel == SEL_W'(i)) q[i] <= (q[i] & ~mask) | (wdata & mask);
         end
      end
   end

   assign bank = q;

endmodule

// File: rtl/pmu_guard.sv
module pmu_guard
   import pmu_acc_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int NUM_CNT    = 6,
   parameter int SEL_W      = 4,
   parameter int ACC_LSB    = 18,
   parameter int FRZ_BIT    = 31,
   parameter int AEN_BIT    = 26,
   parameter int AOCC_BIT   = 7,
   parameter int FCP_FIRST  = 61,
   parameter int FCP_STRIDE = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [SEL_W-1:0]  req_sel,
   input  logic              priv,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              done,
   output logic              exc_valid,
   output logic [1:0]        exc_cause
);

   localparam int NREG = CTRL_REGS + NUM_CNT;
   localparam logic [SEL_W-1:0] SEL_C5 = SEL_W'(CTRL_REGS + 4);
   localparam logic [SEL_W-1:0] SEL_C6 = SEL_W'(CTRL_REGS + 5);
   localparam logic [DATA_W-1:0] CTL0_UMASK = (DATA_W'(1) << FRZ_BIT) |
                                              (DATA_W'(1) << AEN_BIT) |
                                              (DATA_W'(1) << AOCC_BIT);

   initial begin
      assert (NUM_CNT >= 6) else $error("pmu_guard: NUM_CNT must be at least 6");
      assert ((1 << SEL_W) >= NREG) else $error("pmu_guard: SEL_W too small");
      assert (ACC_LSB + 1 < DATA_W) else $error("pmu_guard: ACC_LSB out of range");
      assert (FCP_FIRST < DATA_W && FCP_FIRST - (NUM_CNT - 1) * FCP_STRIDE >= 0)
         else $error("pmu_guard: freeze bit layout out of range");
   end

   logic [NREG-1:0][DATA_W-1:0] bank;
   logic [1:0]                  acc;
   logic                        sel_ok;
   logic                        allow;
   exc_cause_e                  cause_c;
   logic [DATA_W-1:0]           mask;
   logic                        we;
   logic [DATA_W-1:0]           rd_word;

   assign acc    = bank[0][ACC_LSB +: 2];
   assign sel_ok = int'(req_sel) < NREG;

   pmu_access_gate #(.SEL_W(SEL_W)) u_gate (
      .priv     (priv),
      .is_write (req_write),
      .sel      (req_sel),
      .sel_c5   (SEL_C5),
      .sel_c6   (SEL_C6),
      .acc      (acc),
      .allow    (allow),
      .cause    (cause_c)
   );

   pmu_user_mask #(
      .DATA_W     (DATA_W),
      .SEL_W      (SEL_W),
      .NUM_CNT    (NUM_CNT),
      .CTL0_UMASK (CTL0_UMASK),
      .FCP_FIRST  (FCP_FIRST),
      .FCP_STRIDE (FCP_STRIDE)
   ) u_mask (
      .priv (priv),
      .sel  (req_sel),
      .mask (mask)
   );

   assign we = req_valid && req_write && allow && sel_ok;

   pmu_reg_bank #(.DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (we),
      .sel   (req_sel),
      .wdata (wdata),
      .mask  (mask),
      .bank  (bank)
   );

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NREG; i++) begin
         if (req_sel == SEL_W'(i)) rd_word = bank[i] & mask;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata     <= '0;
         done      <= 1'b0;
         exc_valid <= 1'b0;
         exc_cause <= 2'd0;
      end else begin
         done      <= req_valid;
         exc_valid <= req_valid && !allow;
         exc_cause <= (req_valid && !allow) ? cause_c : CAUSE_NONE;
         if (req_valid && !req_write && allow) rdata <= rd_word;
      end
   end

   // R2
   done_follow_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> done);
   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !done);
   // R11
   exc_code_chk: assert property (@(posedge clk) disable iff (rst)
      exc_valid |-> (exc_cause != 2'd0));
   // R11
   exc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !exc_valid |-> (exc_cause == 2'd0));
   // R11
   refuse_hold_chk: assert property (@(posedge clk) disable iff (rst)
      exc_valid |-> ($stable(bank) && $stable(rdata)));
   // R3
   priv_noexc_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && priv) |=> !exc_valid);
   // R5
   emu_cause_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !priv && req_write && acc == 2'b00) |=> (exc_cause == 2'd2));
   // R8
   ctl0_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !priv && req_write && req_sel == '0) |=>
      ((bank[0] & ~CTL0_UMASK) == ($past(bank[0]) & ~CTL0_UMASK)));

endmodule

// File: tb/pmu_guard_test.sv
`timescale 1ns/1ps
module pmu_guard_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [3:0]  req_sel = 4'd0;
   logic        priv = 1'b0;
   logic [63:0] wdata = 64'd0;
   logic [63:0] rdata;
   logic        done;
   logic        exc_valid;
   logic [1:0]  exc_cause;

   int errors = 0;
   int checks = 0;

   localparam logic [63:0] M0 = (64'd1 << 31) | (64'd1 << 26) | (64'd1 << 7);
   localparam logic [63:0] M2 = (64'd1 << 61) | (64'd1 << 52) | (64'd1 << 43) |
                                (64'd1 << 34) | (64'd1 << 25) | (64'd1 << 16);

   always #10 clk = ~clk;

   pmu_guard uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_sel(req_sel), .priv(priv), .wdata(wdata), .rdata(rdata),
      .done(done), .exc_valid(exc_valid), .exc_cause(exc_cause)
   );

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // drive on a falling edge, result sampled on the next falling edge
   task automatic access(bit p, bit w, logic [3:0] s, logic [63:0] d);
      @(negedge clk);
      req_valid = 1'b1; priv = p; req_write = w; req_sel = s; wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic chk_exc(string req, string what, bit v, logic [1:0] c);
      chk(req, {what, " exc_valid"}, {63'd0, exc_valid}, {63'd0, v});
      chk(req, {what, " exc_cause"}, {62'd0, exc_cause}, {62'd0, c});
   endtask

   task automatic set_acc(logic [1:0] a);
      access(1'b1, 1'b1, 4'd0, {44'd0, a, 18'd0});
   endtask

   task automatic priv_expect(string req, string what, logic [3:0] s, logic [63:0] exp);
      access(1'b1, 1'b0, s, 64'd0);
      chk(req, what, rdata, exp);
   endtask

   task automatic t_reset();
      chk("R1", "rdata after reset", rdata, 64'd0);
      chk("R1", "done after reset", {63'd0, done}, 64'd0);
      chk_exc("R1", "after reset", 1'b0, 2'd0);
      for (int i = 0; i < 9; i++) priv_expect("R1", "register cleared", 4'(i), 64'd0);
   endtask

   task automatic t_done();
      access(1'b1, 1'b0, 4'd2, 64'd0);
      chk("R2", "done after request", {63'd0, done}, 64'd1);
      @(negedge clk);
      chk("R2", "done one cycle only", {63'd0, done}, 64'd0);
   endtask

   task automatic t_priv();
      for (int i = 0; i < 9; i++) begin
         access(1'b1, 1'b1, 4'(i), 64'hC3A5_0F1E_0000_0000 | 64'(i * 3 + 1));
         chk_exc("R3", "privileged write", 1'b0, 2'd0);
      end
      for (int i = 0; i < 9; i++)
         priv_expect("R3", "privileged full readback", 4'(i),
                     64'hC3A5_0F1E_0000_0000 | 64'(i * 3 + 1));
   endtask

   task automatic t_read_gate();
      access(1'b1, 1'b1, 4'd2, 64'h0123_4567_89AB_CDEF);
      access(1'b1, 1'b1, 4'd3, 64'h1111_2222_3333_4444);
      set_acc(2'b00);
      access(1'b0, 1'b0, 4'd2, 64'd0);
      chk("R4", "user read acc=00", rdata, 64'h0123_4567_89AB_CDEF);
      chk_exc("R4", "user read acc=00", 1'b0, 2'd0);
      set_acc(2'b10);
      access(1'b0, 1'b0, 4'd3, 64'd0);
      chk("R4", "user read acc=10", rdata, 64'h1111_2222_3333_4444);
      set_acc(2'b11);
      access(1'b0, 1'b0, 4'd2, 64'd0);
      chk("R4", "user read acc=11", rdata, 64'h0123_4567_89AB_CDEF);
      set_acc(2'b01);
      access(1'b0, 1'b0, 4'd3, 64'd0);
      chk_exc("R4", "user read acc=01 refused", 1'b1, 2'd1);
      chk("R11", "rdata held on refusal", rdata, 64'h0123_4567_89AB_CDEF);
      @(negedge clk);
      chk_exc("R11", "exception one cycle", 1'b0, 2'd0);
   endtask

   task automatic t_write_gate();
      access(1'b1, 1'b1, 4'd2, 64'hAAAA_0000_5555_FFFF);
      set_acc(2'b00);
      access(1'b0, 1'b1, 4'd2, 64'h1234_1234_1234_1234);
      chk_exc("R5", "user write acc=00", 1'b1, 2'd2);
      priv_expect("R11", "refused write acc=00 kept", 4'd2, 64'hAAAA_0000_5555_FFFF);
      set_acc(2'b01);
      access(1'b0, 1'b1, 4'd2, 64'h1234_1234_1234_1234);
      chk_exc("R5", "user write acc=01", 1'b1, 2'd1);
      priv_expect("R11", "refused write acc=01 kept", 4'd2, 64'hAAAA_0000_5555_FFFF);
      set_acc(2'b10);
      access(1'b0, 1'b1, 4'd2, 64'h1234_1234_1234_1234);
      chk_exc("R5", "user write acc=10", 1'b0, 2'd0);
      priv_expect("R5", "write acc=10 landed", 4'd2, 64'h1234_1234_1234_1234);
      set_acc(2'b11);
      access(1'b0, 1'b1, 4'd2, 64'h9876_5432_10FE_DCBA);
      chk_exc("R5", "user write acc=11", 1'b0, 2'd0);
      priv_expect("R10", "aux full width write", 4'd2, 64'h9876_5432_10FE_DCBA);
   endtask

   task automatic t_excl();
      access(1'b1, 1'b1, 4'd7, 64'h5555_AAAA_5555_AAAA);
      access(1'b1, 1'b1, 4'd8, 64'h6666_9999_6666_9999);
      set_acc(2'b11);
      access(1'b0, 1'b0, 4'd7, 64'd0);
      chk_exc("R6", "user read counter5 acc=11", 1'b1, 2'd1);
      access(1'b0, 1'b1, 4'd8, 64'd0);
      chk_exc("R6", "user write counter6 acc=11", 1'b1, 2'd1);
      priv_expect("R6", "counter6 unchanged", 4'd8, 64'h6666_9999_6666_9999);
      access(1'b0, 1'b0, 4'd6, 64'd0);
      chk_exc("R6", "user read counter4 acc=11", 1'b0, 2'd0);
      set_acc(2'b10);
      access(1'b0, 1'b1, 4'd8, 64'hFEDC_BA98_7654_3210);
      chk_exc("R6", "user write counter6 acc=10", 1'b0, 2'd0);
      priv_expect("R10", "counter6 full width", 4'd8, 64'hFEDC_BA98_7654_3210);
      set_acc(2'b00);
      access(1'b0, 1'b0, 4'd7, 64'd0);
      chk("R10", "user read counter5 acc=00", rdata, 64'h5555_AAAA_5555_AAAA);
   endtask

   task automatic t_ctl0();
      access(1'b1, 1'b1, 4'd0, 64'hFFFF_FFFF_FFFB_FFFF);  // acc=10
      access(1'b0, 1'b0, 4'd0, 64'd0);
      chk("R7", "user read main control", rdata, M0);
      access(1'b0, 1'b1, 4'd0, 64'd0);
      chk_exc("R8", "user write main control", 1'b0, 2'd0);
      priv_expect("R8", "only exposed bits cleared", 4'd0,
                  64'hFFFF_FFFF_FFFB_FFFF & ~M0);
      access(1'b0, 1'b1, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF);
      priv_expect("R8", "field kept on user write", 4'd0, 64'hFFFF_FFFF_FFFB_FFFF);
   endtask

   task automatic t_ctl2();
      set_acc(2'b10);
      access(1'b1, 1'b1, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF);
      access(1'b0, 1'b0, 4'd1, 64'd0);
      chk("R9", "user read second control", rdata, M2);
      access(1'b0, 1'b1, 4'd1, 64'd0);
      priv_expect("R9", "user write second control", 4'd1, ~M2);
      access(1'b0, 1'b1, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF);
      priv_expect("R9", "freeze bits set again", 4'd1, 64'hFFFF_FFFF_FFFF_FFFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_done();
      t_priv();
      t_read_gate();
      t_write_gate();
      t_excl();
      t_ctl0();
      t_ctl2();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule